// File: doc/BRIEF.md
# SAR converter control core

This block is the digital half of a successive-approximation converter that is driven through a chip-select parallel interface. The host pulses an active-low chip select. The level of a read/convert line at each falling edge picks the next step. In idle, an edge with read/convert low powers up the reference and starts acquisition. The next edge starts the conversion and stores a choice of reference power state for after the conversion. Once the result is ready, an edge with read/convert high puts the result on the data bus.

During a conversion the block resolves one bit per bit-period, set by a parameterised clock divider, starting from the MSB. It presents a trial code to an external DAC and reads back one comparator bit, which says whether the sampled input lies below the trial level. An active-low end-of-conversion flag tells the host that data is waiting. The data bus is driven as a value plus an output-enable, so the pad ring can make it tri-state. The bus is either as wide as the result, or byte-wide with a high-byte select. A synchronous clear returns the control to idle.

Top module: `sar_ctrl_top`

## Requirements
- R1: In idle, a chip-select falling edge with read/convert low enters acquisition and sets `refOn` to 1. A falling edge with read/convert high in idle is ignored: `refOn` and the step sequence are unchanged.
- R2: In acquisition, the next chip-select falling edge starts the conversion. The read/convert level sampled at that edge is stored as the power-down choice: 1 means shutdown, 0 means standby.
- R3: With a result waiting, a chip-select falling edge with read/convert high sets `dataOe` to 1. The later chip-select rise clears `dataOe` and returns to idle.
- R4: `dataOe` is 0 in idle, in acquisition and during conversion.
- R5: Conversion is MSB first. The first trial code is `1 << (RES_BITS-1)`. Each later trial holds the decided bits with the current bit set. A bit is cleared when `cmpBelow` is 1 (input below the trial level). The result is the straight-binary code of the input.
- R6: `eocN` goes to 0 when the conversion finishes. It stays 0 until chip select rises after the read, then returns to 1.
- R7: When `BYTE_BUS` is 1, `hiByteSel` = 1 drives result bits [RES_BITS-1:RES_BITS/2] and `hiByteSel` = 0 drives bits [RES_BITS/2-1:0]. When `BYTE_BUS` is 0, the whole result is driven.
- R8: `clearIn` high while the synchronised chip select is high returns the control to idle, with `eocN` = 1, `dataOe` = 0 and `refOn` = 0. The next falling edge with read/convert low begins acquisition.
- R9: When the conversion finishes, `refOn` becomes the inverse of the stored power-down choice. It keeps that value until the next acquisition sets it to 1.
- R10: Chip-select falling edges during a conversion are ignored. While a result waits, falling edges with read/convert low are ignored. In both cases `dataOe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| clearIn | input | 1 | Synchronous return-to-idle request |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdConv | input | 1 | Read/convert qualifier, asynchronous |
| hiByteSel | input | 1 | High-byte select for the byte-wide bus |
| cmpBelow | input | 1 | Comparator: input below trial level |
| trialCode | output | RES_BITS | Trial code to the DAC |
| eocN | output | 1 | End of conversion, active low |
| dataOut | output | BUS_W | Result bus value |
| dataOe | output | 1 | Bus drive enable (0 = high impedance) |
| refOn | output | 1 | Reference power state, 1 = on |

## Verification
The bench builds two copies that share the chip-select and read/convert wires. The first has 16 bits, a divider of 1 and the byte-wide bus. The second has 8 bits, a divider of 3 and the full-width bus. A behavioural comparator drives each copy from one sweep of input values: multiples of 257 and walking ones and zeros. This covers every 8-bit code exhaustively, and covers both bytes, the extremes and each single bit of the 16-bit path. Both power-down choices alternate across the sweep. Each conversion also has ignored edges injected during the conversion and while the result waits.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_HOLD,
    ST_READ
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // sample taken: restart the approximation
  } dpStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clearIn,
  input  logic      csN,
  input  logic      rdConv,
  input  logic      convDone,
  output dpStrobe_t strb,
  output logic      eocN,
  output logic      dataOe,
  output logic      refOn
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csSync;
  logic [TOP:0] rcSync;
  logic         csPrev;
  logic         pdBit;
  ctrlState_e   state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      rcSync <= '0;
      csPrev <= 1'b1;
    end else begin
      csSync <= {csSync[TOP-1:0], csN};
      rcSync <= {rcSync[TOP-1:0], rdConv};
      csPrev <= csSync[TOP];
    end
  end

  logic csNow, rcNow, csFall, csRise;
  assign csNow  = csSync[TOP];
  assign rcNow  = rcSync[TOP];
  assign csFall = csPrev & ~csNow;
  assign csRise = ~csPrev & csNow;

  always_comb begin
    strb      = '0;
    strb.load = (state == ST_ACQ) && csFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      eocN   <= 1'b1;
      dataOe <= 1'b0;
      refOn  <= 1'b0;
      pdBit  <= 1'b0;
    end else if (clearIn && csNow) begin
      state  <= ST_IDLE;
      eocN   <= 1'b1;
      dataOe <= 1'b0;
      refOn  <= 1'b0;
      pdBit  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (csFall && !rcNow) begin
          state <= ST_ACQ;
          refOn <= 1'b1;
        end
        ST_ACQ: if (csFall) begin
          state <= ST_CONV;
          pdBit <= rcNow;
        end
        ST_CONV: if (convDone) begin
          state <= ST_HOLD;
          eocN  <= 1'b0;
          refOn <= ~pdBit;
        end
        ST_HOLD: if (csFall && rcNow) begin
          state  <= ST_READ;
          dataOe <= 1'b1;
        end
        ST_READ: if (csRise) begin
          state  <= ST_IDLE;
          dataOe <= 1'b0;
          eocN   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_pkg::*;
#(
  parameter int RES_BITS = 16,
  parameter int CLK_DIV  = 4,
  parameter int BYTE_BUS = 1,
  localparam int BUS_W   = (BYTE_BUS != 0) ? RES_BITS / 2 : RES_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic                cmpBelow,
  input  logic                hiByteSel,
  output logic [RES_BITS-1:0] trialCode,
  output logic                convDone,
  output logic [BUS_W-1:0]    dataOut
);
  localparam int PTR_W    = $clog2(RES_BITS);
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int SHIFT_HI = (BYTE_BUS != 0) ? BUS_W : 0;

  logic [RES_BITS-1:0] code;
  logic [RES_BITS-1:0] result;
  logic [PTR_W-1:0]    ptr;
  logic [DIV_W-1:0]    divCnt;
  logic                busy;
  logic                tick;

  assign tick = busy && (divCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code     <= '0;
      result   <= '0;
      ptr      <= '0;
      divCnt   <= '0;
      busy     <= 1'b0;
      convDone <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (strb.load) begin
        code   <= RES_BITS'(1) << (RES_BITS - 1);
        ptr    <= PTR_W'(RES_BITS - 1);
        divCnt <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        if (tick) begin
          divCnt    <= '0;
          code[ptr] <= ~cmpBelow;
          if (ptr == '0) begin
            busy     <= 1'b0;
            convDone <= 1'b1;
            result   <= {code[RES_BITS-1:1], ~cmpBelow};
          end else begin
            code[ptr - 1'b1] <= 1'b1;
            ptr              <= ptr - 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign trialCode = code;
  assign dataOut   = hiByteSel ? BUS_W'(result >> SHIFT_HI) : BUS_W'(result);
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top
  import sar_pkg::*;
#(
  parameter int RES_BITS = 16,
  parameter int CLK_DIV  = 4,
  parameter int BYTE_BUS = 1,
  localparam int BUS_W   = (BYTE_BUS != 0) ? RES_BITS / 2 : RES_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearIn,
  input  logic                csN,
  input  logic                rdConv,
  input  logic                hiByteSel,
  input  logic                cmpBelow,
  output logic [RES_BITS-1:0] trialCode,
  output logic                eocN,
  output logic [BUS_W-1:0]    dataOut,
  output logic                dataOe,
  output logic                refOn
);
  dpStrobe_t strb;
  logic      convDone;

  sar_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .csN(csN), .rdConv(rdConv),
    .convDone(convDone), .strb(strb), .eocN(eocN), .dataOe(dataOe), .refOn(refOn)
  );

  sar_dp #(.RES_BITS(RES_BITS), .CLK_DIV(CLK_DIV), .BYTE_BUS(BYTE_BUS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpBelow(cmpBelow), .hiByteSel(hiByteSel),
    .trialCode(trialCode), .convDone(convDone), .dataOut(dataOut)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int RES_BITS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                eocN,
  input logic                dataOe,
  input logic                refOn,
  input logic                loadStb,
  input logic                dpDone,
  input logic [RES_BITS-1:0] trialCode
);
  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    eocN |-> !dataOe);

  p_first_trial_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (trialCode == (RES_BITS'(1) << (RES_BITS - 1))));

  p_read_after_eoc_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> (!eocN && $past(!eocN)));

  p_eoc_from_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> $past(dpDone));

  p_ref_on_conv_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> refOn);
endmodule

bind sar_ctrl_top sar_ctrl_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .eocN(eocN), .dataOe(dataOe), .refOn(refOn),
  .loadStb(strb.load), .dpDone(convDone), .trialCode(trialCode)
);

// File: tb/sar_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module sar_ctrl_top_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rstN = 1'b0, clearIn = 1'b0, csN = 1'b1, rdConv = 1'b0, hiByteSel = 1'b0;
  logic [15:0] vin = '0;

  logic [15:0] trialB;
  logic [7:0]  dataB;
  logic        eocB, oeB, refB, cmpB;
  logic [7:0]  trialW;
  logic [7:0]  dataW;
  logic        eocW, oeW, refW, cmpW;

  assign cmpB = (vin < trialB);
  assign cmpW = (vin[7:0] < trialW);

  sar_ctrl_top #(.RES_BITS(16), .CLK_DIV(1), .BYTE_BUS(1)) dut_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .csN(csN), .rdConv(rdConv),
    .hiByteSel(hiByteSel), .cmpBelow(cmpB), .trialCode(trialB), .eocN(eocB),
    .dataOut(dataB), .dataOe(oeB), .refOn(refB)
  );

  sar_ctrl_top #(.RES_BITS(8), .CLK_DIV(3), .BYTE_BUS(0)) dutW_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .csN(csN), .rdConv(rdConv),
    .hiByteSel(hiByteSel), .cmpBelow(cmpW), .trialCode(trialW), .eocN(eocW),
    .dataOut(dataW), .dataOe(oeW), .refOn(refW)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic csFallWith(input logic rc);
    rdConv = rc;
    csN = 1'b0;
    tick(4);
  endtask

  task automatic csRise();
    csN = 1'b1;
    tick(4);
  endtask

  task automatic convert(input logic [15:0] v, input logic pd, input bit holdPoke);
    vin = v;
    csFallWith(1'b0);
    chk("R1 acquire refOn", {refW, refB}, 2'b11);
    chk("R9 refOn back on at acquisition", refB, 1'b1);
    chk("R4 bus off in acquisition", {oeW, oeB}, 2'b00);
    chk("R6 eoc high in acquisition", {eocW, eocB}, 2'b11);
    csRise();
    csFallWith(pd);
    chk("R4 bus off in conversion", {oeW, oeB}, 2'b00);
    csRise();
    csFallWith(1'b1);
    chk("R10 edge during conversion ignored", {oeW, oeB}, 2'b00);
    csRise();
    for (int k = 0; k < 200 && (eocB || eocW); k++) tick(1);
    chk("R6 eoc low at end of conversion", {eocW, eocB}, 2'b00);
    chk("R2 R9 refOn from stored choice", {refW, refB}, {!pd, !pd});
    if (holdPoke) begin
      csFallWith(1'b0);
      chk("R10 rc-low edge while waiting ignored", {oeW, oeB, eocW, eocB}, 4'b0000);
      csRise();
    end
    csFallWith(1'b1);
    chk("R3 bus driven on read", {oeW, oeB}, 2'b11);
    hiByteSel = 1'b1;
    #1;
    chk("R5 R7 high byte", dataB, v[15:8]);
    hiByteSel = 1'b0;
    #1;
    chk("R5 R7 low byte", dataB, v[7:0]);
    chk("R5 R7 word bus", dataW, v[7:0]);
    csRise();
    chk("R3 bus released", {oeW, oeB}, 2'b00);
    chk("R6 eoc high after read", {eocW, eocB}, 2'b11);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    chk("R8 reset state", {eocB, oeB, refB}, 3'b100);

    // R1: rc-high edge in idle is ignored
    csFallWith(1'b1);
    chk("R1 ignored edge refOn", refB, 1'b0);
    csRise();
    csFallWith(1'b0);
    chk("R1 acquisition after ignored edge", refB, 1'b1);
    tick(60);
    chk("R1 no conversion started", {eocW, eocB}, 2'b11);
    csRise();

    // R8: clear from acquisition
    clearIn = 1'b1; tick(1); clearIn = 1'b0; tick(1);
    chk("R8 clear state", {eocB, oeB, refB}, 3'b100);
    csFallWith(1'b0);
    chk("R8 acquisition after clear", refB, 1'b1);
    tick(60);
    chk("R8 no conversion after clear", {eocW, eocB}, 2'b11);
    csRise();
    clearIn = 1'b1; tick(1); clearIn = 1'b0; tick(1);

    for (int i = 0; i < 256; i++) convert(16'(i * 257), i[0], i[2]);
    for (int b = 0; b < 16; b++) begin
      convert(16'(1) << b, b[0], 1'b0);
      convert(~(16'(1) << b), ~b[0], 1'b0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nFail, nChecks);
      $finish;
    end
  end
endmodule